// File: doc/BRIEF.md
# Page Write Collector and Program Sequencer

This block sits behind a two-wire serial memory's protocol engine. It gathers the data bytes of one write transaction into a 128-byte page buffer. When the transaction closes, it commits those bytes to the storage array in a single self-timed program cycle. The protocol engine gives it four strobes: one when a Start condition is seen, one when the address phase is done (together with the 16-bit start address), one for each received data byte, and one when a Stop condition is seen. A write-protect input decides whether a closed transaction is committed or discarded.

The 16-bit address splits into a 9-bit page number and a 7-bit in-page offset. Only the offset advances as bytes arrive, and it wraps inside the page. During the program cycle the block raises a busy flag for a fixed number of clock cycles. The `PROG_CYCLES` parameter stands in for the worst-case self-timed write time. In that window the block walks the page in ascending offset order and issues one array write request for each location that received data. Every strobe that arrives while busy is dropped.

Top module: `page_prog_seq`

## Requirements
- R1: After reset `busy_o` and `wr_req_o` are low, and the block waits for an address phase.
- R2: An `addr_vld_i` pulse while idle loads `addr_i`. Bits [15:7] select the page and bits [6:0] give the first offset. Every array write of the transaction carries that page in `wr_addr_o[15:7]`.
- R3: Each `byte_vld_i` pulse stores `byte_i` at the current offset. The offset then advances by one modulo 128, so offset 127 is followed by offset 0 of the same page.
- R4: When a transaction carries more than 128 bytes, a later byte replaces the earlier byte at the same offset, and only the last value is written.
- R5: No array write happens before Stop. A Stop that closes a transaction with at least one byte, with `wp_i` low at that cycle, raises `busy_o` in the next cycle and holds it for exactly `PROG_CYCLES` cycles.
- R6: While busy, exactly one `wr_req_o` pulse is issued for each offset that received data, in ascending offset order. Each pulse carries that offset's last received byte on `wr_data_o`. No request is issued for any other offset.
- R7: A `start_i` pulse that arrives before Stop discards the collected bytes. No program cycle follows.
- R8: If `wp_i` is high at the Stop cycle, the bytes are discarded and no program cycle runs. The level of `wp_i` during byte collection has no effect; only its level at Stop counts.
- R9: While busy, `start_i`, `addr_vld_i`, `byte_vld_i` and `stop_i` are ignored. After the cycle the block is idle again, and nothing received during busy is programmed.
- R10: A Stop with no data bytes since the address phase starts no program cycle.
- R11: Each program cycle, discard or protected Stop leaves the buffer empty, so the next transaction writes only its own locations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start condition seen on the bus |
| addr_vld_i | input | 1 | Address phase complete; `addr_i` valid |
| addr_i | input | 16 | Start address (page and offset) |
| byte_vld_i | input | 1 | One data byte received |
| byte_i | input | 8 | Received data byte |
| stop_i | input | 1 | Stop condition seen on the bus |
| wp_i | input | 1 | Write protect for the main array |
| busy_o | output | 1 | Self-timed program cycle in progress |
| wr_req_o | output | 1 | Array write request, one cycle per byte |
| wr_addr_o | output | 16 | Array address of the request |
| wr_data_o | output | 8 | Array data of the request |

## Verification
The embedded properties are checked on every cycle. They cover these points: write requests stay inside the busy window and never appear while bytes are still being collected; busy ends only on the timer's final count; busy rises only after a Stop with write protect low; the page number holds steady during programming; and the buffer is empty once busy falls. The other behaviours need the bench's scenarios, because they depend on what was written and when. These include offset wrap-around, last-write-wins overwriting, the ascending set of programmed locations and their data, discard on an early Start, sampling of protect only at Stop, and the dropping of strobes that arrive while busy.

// File: rtl/pps_pkg.sv
package pps_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_FILL = 2'd1,
    SEQ_PROG = 2'd2
  } seq_st_e;
endpackage

// File: rtl/pps_page_buf.sv
module pps_page_buf #(
  parameter int PAGE_AW = 7,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we_i,
  input  logic [PAGE_AW-1:0] we_off_i,
  input  logic [DATA_W-1:0]  we_data_i,
  input  logic               clr_i,
  input  logic [PAGE_AW-1:0] rd_off_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic               rd_dirty_o,
  output logic               any_dirty_o
);
  localparam int DEPTH = 1 << PAGE_AW;

  logic [DATA_W-1:0] store_q [DEPTH];
  logic [DEPTH-1:0]  dirty_q;

  always_ff @(posedge clk) begin
    if (we_i) store_q[we_off_i] <= we_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dirty_q <= '0;
    else if (clr_i) dirty_q <= '0;
    else if (we_i)  dirty_q[we_off_i] <= 1'b1;
  end

  assign rd_data_o   = store_q[rd_off_i];
  assign rd_dirty_o  = dirty_q[rd_off_i];
  assign any_dirty_o = |dirty_q;
endmodule

// File: rtl/pps_prog_timer.sv
module pps_prog_timer #(
  parameter int CYCLES = 200
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr_i,
  input  logic                        en_i,
  output logic [$clog2(CYCLES+1)-1:0] cnt_o,
  output logic                        last_o
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (clr_i)               cnt_q <= '0;
    else if (en_i && !last_o)     cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign last_o = en_i && (cnt_q == CW'(CYCLES - 1));

  AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(CYCLES - 1)); // R5
endmodule

// File: rtl/page_prog_seq.sv
module page_prog_seq
  import pps_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int PAGE_AW     = 7,
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              addr_vld_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              stop_i,
  input  logic              wp_i,
  output logic              busy_o,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  localparam int PAGE_BYTES = 1 << PAGE_AW;
  localparam int PG_W       = ADDR_W - PAGE_AW;
  localparam int CW         = $clog2(PROG_CYCLES + 1);

  function automatic logic [PAGE_AW-1:0] step_off(input logic [PAGE_AW-1:0] o);
    return o + 1'b1;
  endfunction

  seq_st_e            st_q;
  logic [PG_W-1:0]    page_q;
  logic [PAGE_AW-1:0] off_q;

  logic               buf_we, buf_clr, launch, tmr_last;
  logic               rd_dirty, any_dirty, in_scan;
  logic [CW-1:0]      tmr_cnt;
  logic [DATA_W-1:0]  rd_data;
  logic [PAGE_AW-1:0] scan_off;

  wire filling = (st_q == SEQ_FILL);
  wire progr   = (st_q == SEQ_PROG);

  assign launch  = filling && !start_i && stop_i && any_dirty && !wp_i;
  assign buf_we  = filling && byte_vld_i && !start_i && !stop_i;
  assign buf_clr = (filling && (start_i || (stop_i && !launch))) ||
                   (progr && tmr_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      page_q <= '0;
      off_q  <= '0;
    end else begin
      unique case (st_q)
        SEQ_IDLE: if (addr_vld_i) begin
          page_q <= addr_i[ADDR_W-1:PAGE_AW];
          off_q  <= addr_i[PAGE_AW-1:0];
          st_q   <= SEQ_FILL;
        end
        SEQ_FILL: begin
          if (start_i)       st_q  <= SEQ_IDLE;
          else if (stop_i)   st_q  <= launch ? SEQ_PROG : SEQ_IDLE;
          else if (buf_we)   off_q <= step_off(off_q);
        end
        SEQ_PROG: if (tmr_last) st_q <= SEQ_IDLE;
        default:  st_q <= SEQ_IDLE;
      endcase
    end
  end

  pps_page_buf #(.PAGE_AW(PAGE_AW), .DATA_W(DATA_W)) u_buf (
    .clk         (clk),
    .rst_n       (rst_n),
    .we_i        (buf_we),
    .we_off_i    (off_q),
    .we_data_i   (byte_i),
    .clr_i       (buf_clr),
    .rd_off_i    (scan_off),
    .rd_data_o   (rd_data),
    .rd_dirty_o  (rd_dirty),
    .any_dirty_o (any_dirty)
  );

  pps_prog_timer #(.CYCLES(PROG_CYCLES)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (launch),
    .en_i   (progr),
    .cnt_o  (tmr_cnt),
    .last_o (tmr_last)
  );

  assign scan_off  = tmr_cnt[PAGE_AW-1:0];
  assign in_scan   = tmr_cnt < CW'(PAGE_BYTES);
  assign busy_o    = progr;
  assign wr_req_o  = progr && in_scan && rd_dirty;
  assign wr_addr_o = {page_q, scan_off};
  assign wr_data_o = rd_data;

  AST_WR_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_o |-> busy_o); // R6
  AST_NO_EARLY_WR: assert property (@(posedge clk) disable iff (!rst_n)
    filling |-> !wr_req_o); // R5
  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(tmr_last)); // R5
  AST_LAUNCH_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> ($past(stop_i) && !$past(wp_i))); // R8
  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !tmr_last) |=> $stable(page_q)); // R9
  AST_BUF_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> !any_dirty); // R11
endmodule

// File: tb/page_prog_seq_tb.sv
module page_prog_seq_tb_top;
  localparam int PROG = 200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 0, addr_vld_i = 0, byte_vld_i = 0, stop_i = 0, wp_i = 0;
  logic [15:0] addr_i = '0;
  logic [7:0]  byte_i = '0;
  logic        busy_o, wr_req_o;
  logic [15:0] wr_addr_o;
  logic [7:0]  wr_data_o;

  int n_chk = 0, n_bad = 0;
  int busy_n = 0, log_n = 0;
  logic [15:0] log_a [256];
  logic [7:0]  log_d [256];
  logic [7:0]  exp_v [128];
  bit          exp_s [128];

  always #4 clk = ~clk;

  page_prog_seq #(.PROG_CYCLES(PROG)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_vld_i(addr_vld_i),
    .addr_i(addr_i), .byte_vld_i(byte_vld_i), .byte_i(byte_i),
    .stop_i(stop_i), .wp_i(wp_i), .busy_o(busy_o), .wr_req_o(wr_req_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
  );

  always @(negedge clk) begin
    if (busy_o) busy_n++;
    if (wr_req_o && log_n < 256) begin
      log_a[log_n] = wr_addr_o;
      log_d[log_n] = wr_data_o;
      log_n++;
    end
  end

  function automatic int wrap_next(input int o);
    return (o == 127) ? 0 : o + 1;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic txn(input logic [15:0] a, input int n, input bit wp_stop,
                     input bit wp_fill, input bit abort, input bit poke,
                     input string tag);
    int off;
    int k;
    bit prog;
    for (int i = 0; i < 128; i++) exp_s[i] = 0;
    busy_n = 0;
    log_n  = 0;
    @(negedge clk);
    addr_vld_i = 1; addr_i = a;
    @(negedge clk);
    addr_vld_i = 0; addr_i = $urandom;
    wp_i = wp_fill;
    off = int'(a[6:0]);
    for (int i = 0; i < n; i++) begin
      byte_vld_i = 1; byte_i = 8'($urandom);
      exp_v[off] = byte_i; exp_s[off] = 1;
      off = wrap_next(off);
      @(negedge clk);
    end
    byte_vld_i = 0;
    wp_i = wp_stop;
    if (abort) start_i = 1; else stop_i = 1;
    check(busy_o == 0 && log_n == 0, "R5", {tag, " nothing before Stop"}, log_n, 0);
    @(negedge clk);
    start_i = 0; stop_i = 0; wp_i = 0;
    prog = !abort && !wp_stop && n > 0;
    check(busy_o == prog, "R5", {tag, " busy after Stop"}, int'(busy_o), int'(prog));
    if (poke) begin
      repeat (3) @(negedge clk);
      addr_vld_i = 1; addr_i = 16'h0300;
      @(negedge clk); addr_vld_i = 0;
      for (int i = 0; i < 3; i++) begin
        byte_vld_i = 1; byte_i = 8'hA5; @(negedge clk);
      end
      byte_vld_i = 0; start_i = 1; @(negedge clk); start_i = 0;
      stop_i = 1; @(negedge clk); stop_i = 0;
    end
    repeat (PROG + 40) @(negedge clk);
    check(busy_n == (prog ? PROG : 0), "R5", {tag, " busy length"}, busy_n,
          prog ? PROG : 0);
    k = 0;
    for (int o = 0; o < 128; o++) if (prog && exp_s[o]) k++;
    check(log_n == k, "R6", {tag, " write count"}, log_n, k);
    k = 0;
    for (int o = 0; o < 128; o++) begin
      if (prog && exp_s[o] && k < log_n) begin
        check(log_a[k] == {a[15:7], 7'(o)}, "R2", {tag, " write address"},
              int'(log_a[k]), int'({a[15:7], 7'(o)}));
        check(log_d[k] == exp_v[o], "R6", {tag, " write data"},
              int'(log_d[k]), int'(exp_v[o]));
        k++;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R5 watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(busy_o == 0 && wr_req_o == 0, "R1", "reset outputs", int'(busy_o), 0);
    rst_n = 1;
    @(negedge clk);
    check(busy_o == 0, "R1", "idle after reset", int'(busy_o), 0);
    txn(16'h1235, 1,   0, 0, 0, 0, "R2 single byte");
    txn(16'hFFE4, 128, 0, 0, 0, 0, "R3 full page wrap");
    txn(16'h807E, 131, 0, 0, 0, 0, "R4 overwrite");
    txn(16'h4010, 5,   0, 0, 1, 0, "R7 start discard");
    txn(16'h4010, 5,   1, 0, 0, 0, "R8 protected stop");
    txn(16'h2200, 6,   0, 1, 0, 0, "R8 protect only during fill");
    txn(16'h2200, 0,   0, 0, 0, 0, "R10 empty stop");
    txn(16'h0A40, 4,   0, 0, 0, 1, "R9 strobes while busy");
    txn(16'h0A41, 2,   0, 0, 0, 0, "R11 fresh buffer");
    for (int r = 0; r < 20; r++) begin
      txn(16'($urandom), 1 + int'($urandom % 140), ($urandom % 5) == 0, $urandom % 2,
          ($urandom % 6) == 0, 0, "R3 random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule